// File: doc/BRIEF.md
# Power Gating Sequence Controller

This always-on controller sequences the shutdown and wakeup of one switchable power domain. A one-cycle request input asks for a power-down or a power-up. The controller then moves three registered control outputs in a fixed order: the power switch enable, the isolation enable and the retention save/restore control. Each output moves a parameterized number of clock cycles after the previous one. It then waits for an acknowledge from the domain, which must arrive within a parameterized deadline.

Power-down order: the switch enable drops, then isolation is raised, then the retention control moves to save. The controller then waits for the acknowledge. Power-up order: the retention control moves to restore, then the switch enable rises, then the controller waits for the acknowledge. Isolation is released only on that acknowledge. A completed sequence ends with a one-cycle done pulse. A missed deadline sends the controller to a fault state. In that state a sticky error is raised, isolation is held on and requests are refused until the error is cleared.

The states are ON, DN_SW, DN_ISO, DN_RET, DN_ACK, OFF, UP_RET, UP_SW, UP_ACK and FAULT. The named transitions are:
- ON→DN_SW on a down request.
- DN_SW→DN_ISO when the switch-off delay expires.
- DN_ISO→DN_RET when the isolation delay expires.
- DN_RET→DN_ACK when the save delay expires.
- DN_ACK→OFF on the acknowledge.
- OFF→UP_RET on an up request.
- UP_RET→UP_SW when the restore delay expires.
- UP_SW→UP_ACK when the switch-on delay expires.
- UP_ACK→ON on the acknowledge.
- DN_ACK→FAULT or UP_ACK→FAULT when the deadline passes.
- FAULT→OFF on an error clear.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, status is ON (code 0), sw_en=1, iso_en=0, ret_save=0, and busy, done and err are 0.
- R2: A req_down sampled at edge E0 while in ON makes sw_en fall at edge E0+SW_DLY.
- R3: iso_en rises ISO_DLY cycles after sw_en falls in a power-down.
- R4: ret_save rises (save) RET_DLY cycles after iso_en rises. Isolation is already on when save begins.
- R5: After the save step, a dom_ack sampled at any of the next ACK_LIMIT edges ends the power-down. On that edge status becomes OFF (code 2) and done is high for exactly one cycle.
- R6: A req_up sampled at edge U0 while in OFF makes ret_save fall (restore) at edge U0+RET_DLY. sw_en then rises ISO_DLY cycles later.
- R7: After the switch-on step, a dom_ack within ACK_LIMIT edges releases iso_en. On that same edge status becomes ON and done pulses for one cycle. iso_en never falls at any other time.
- R8: If no dom_ack is sampled in the ACK_LIMIT edges after the last step, status becomes ERROR (code 4) on the last of them. err is then set and sticky, iso_en is 1, and sw_en and ret_save keep their values.
- R9: In ERROR, req_down and req_up are ignored. An err_clr moves to OFF on the next edge, with err=0, sw_en=0, iso_en=1 and ret_save=1.
- R10: Requests that arrive during a sequence are ignored. So are req_up in ON, req_down in OFF, and any dom_ack outside the two acknowledge-wait states.
- R11: status encodes the state as ON=0, POWERING_DOWN=1, OFF=2, POWERING_UP=3, ERROR=4.
- R12: busy is high exactly while status is POWERING_DOWN or POWERING_UP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_down | input | 1 | Power-down request, sampled in ON |
| req_up | input | 1 | Power-up request, sampled in OFF |
| dom_ack | input | 1 | Power-state acknowledge from the gated domain |
| err_clr | input | 1 | Clears the sticky error, sampled in ERROR |
| sw_en | output | 1 | Power switch enable (1 = domain supplied) |
| iso_en | output | 1 | Isolation enable (1 = outputs clamped) |
| ret_save | output | 1 | Retention control (1 = save/hold, 0 = restore/run) |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | Sticky acknowledge-timeout error |
| status | output | 3 | Encoded controller state |

## Verification
Take a request sampled at edge E0. A power-down step is due at edge E0+SW_DLY, E0+SW_DLY+ISO_DLY or E0+SW_DLY+ISO_DLY+RET_DLY; the power-up steps follow the same pattern. Completion or fault falls on the edge that samples the acknowledge, or on the ACK_LIMIT-th edge after the last step. The bench numbers its falling-edge samples i=1,2,… after E0, so a change made at edge E0+k is checked from sample i=k+1 onward. Every output is compared on every sample against a closed-form function of i. The acknowledge delay is swept over every legal value in both directions, plus the no-acknowledge case. Stray requests and an early acknowledge are injected inside each sequence.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [3:0] {
        ST_ON, ST_DN_SW, ST_DN_ISO, ST_DN_RET, ST_DN_ACK,
        ST_OFF, ST_UP_RET, ST_UP_SW, ST_UP_ACK, ST_FAULT
    } seq_state_e;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_SW_OFF, ACT_ISO_ON, ACT_SAVE, ACT_DONE_DN,
        ACT_RESTORE, ACT_SW_ON, ACT_DONE_UP, ACT_FAULT, ACT_CLEAR
    } ctl_act_e;

    localparam logic [2:0] STAT_ON   = 3'd0;
    localparam logic [2:0] STAT_DOWN = 3'd1;
    localparam logic [2:0] STAT_OFF  = 3'd2;
    localparam logic [2:0] STAT_UP   = 3'd3;
    localparam logic [2:0] STAT_ERR  = 3'd4;

    function automatic logic [2:0] status_of(input seq_state_e s);
        unique case (s)
            ST_ON:                                       return STAT_ON;
            ST_DN_SW, ST_DN_ISO, ST_DN_RET, ST_DN_ACK:  return STAT_DOWN;
            ST_OFF:                                      return STAT_OFF;
            ST_UP_RET, ST_UP_SW, ST_UP_ACK:             return STAT_UP;
            default:                                     return STAT_ERR;
        endcase
    endfunction

endpackage

// File: rtl/pgs_countdown.sv
module pgs_countdown #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgs_ctl_regs.sv
module pgs_ctl_regs
    import pgs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_act_e act,
    output logic     sw_en,
    output logic     iso_en,
    output logic     ret_save,
    output logic     done,
    output logic     err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en    <= 1'b1;
            iso_en   <= 1'b0;
            ret_save <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (act)
                ACT_SW_OFF:  sw_en    <= 1'b0;
                ACT_ISO_ON:  iso_en   <= 1'b1;
                ACT_SAVE:    ret_save <= 1'b1;
                ACT_DONE_DN: done     <= 1'b1;
                ACT_RESTORE: ret_save <= 1'b0;
                ACT_SW_ON:   sw_en    <= 1'b1;
                ACT_DONE_UP: begin
                    iso_en <= 1'b0;
                    done   <= 1'b1;
                end
                ACT_FAULT: begin
                    err    <= 1'b1;
                    iso_en <= 1'b1;
                end
                ACT_CLEAR: begin
                    err      <= 1'b0;
                    sw_en    <= 1'b0;
                    iso_en   <= 1'b1;
                    ret_save <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    save_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_save) |-> iso_en);

    // R6
    restore_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> !ret_save);

    // R8
    err_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> iso_en);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pgs_pkg::*;
#(
    parameter int SW_DLY    = 2,
    parameter int ISO_DLY   = 3,
    parameter int RET_DLY   = 4,
    parameter int ACK_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_down,
    input  logic       req_up,
    input  logic       dom_ack,
    input  logic       err_clr,
    output logic       sw_en,
    output logic       iso_en,
    output logic       ret_save,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [2:0] status
);
    localparam int MAX_A = (SW_DLY > ISO_DLY) ? SW_DLY : ISO_DLY;
    localparam int MAX_B = (RET_DLY > ACK_LIMIT) ? RET_DLY : ACK_LIMIT;
    localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXD + 1);

    localparam logic [CW-1:0] LD_SW  = CW'(SW_DLY - 1);
    localparam logic [CW-1:0] LD_ISO = CW'(ISO_DLY - 1);
    localparam logic [CW-1:0] LD_RET = CW'(RET_DLY - 1);
    localparam logic [CW-1:0] LD_ACK = CW'(ACK_LIMIT - 1);

    seq_state_e    state_q, state_d;
    ctl_act_e      act;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        act      = ACT_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_ON: if (req_down) begin
                state_d  = ST_DN_SW;
                tmr_load = 1'b1;
                tmr_val  = LD_SW;
            end
            ST_DN_SW: if (tmr_zero) begin
                state_d  = ST_DN_ISO;
                act      = ACT_SW_OFF;
                tmr_load = 1'b1;
                tmr_val  = LD_ISO;
            end
            ST_DN_ISO: if (tmr_zero) begin
                state_d  = ST_DN_RET;
                act      = ACT_ISO_ON;
                tmr_load = 1'b1;
                tmr_val  = LD_RET;
            end
            ST_DN_RET: if (tmr_zero) begin
                state_d  = ST_DN_ACK;
                act      = ACT_SAVE;
                tmr_load = 1'b1;
                tmr_val  = LD_ACK;
            end
            ST_DN_ACK: begin
                if (dom_ack) begin
                    state_d = ST_OFF;
                    act     = ACT_DONE_DN;
                end else if (tmr_zero) begin
                    state_d = ST_FAULT;
                    act     = ACT_FAULT;
                end
            end
            ST_OFF: if (req_up) begin
                state_d  = ST_UP_RET;
                tmr_load = 1'b1;
                tmr_val  = LD_RET;
            end
            ST_UP_RET: if (tmr_zero) begin
                state_d  = ST_UP_SW;
                act      = ACT_RESTORE;
                tmr_load = 1'b1;
                tmr_val  = LD_ISO;
            end
            ST_UP_SW: if (tmr_zero) begin
                state_d  = ST_UP_ACK;
                act      = ACT_SW_ON;
                tmr_load = 1'b1;
                tmr_val  = LD_ACK;
            end
            ST_UP_ACK: begin
                if (dom_ack) begin
                    state_d = ST_ON;
                    act     = ACT_DONE_UP;
                end else if (tmr_zero) begin
                    state_d = ST_FAULT;
                    act     = ACT_FAULT;
                end
            end
            ST_FAULT: if (err_clr) begin
                state_d = ST_OFF;
                act     = ACT_CLEAR;
            end
            default: state_d = ST_FAULT;
        endcase
    end

    pgs_countdown #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pgs_ctl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .sw_en    (sw_en),
        .iso_en   (iso_en),
        .ret_save (ret_save),
        .done     (done),
        .err      (err)
    );

    assign status = status_of(state_q);
    assign busy   = (status == STAT_DOWN) || (status == STAT_UP);

    // R2
    sw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_en) |-> (status == STAT_DOWN) ||
                         (status == STAT_OFF && $past(status) == STAT_ERR));

    // R7
    iso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> done && status == STAT_ON);

    // R9
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> status == STAT_OFF && !sw_en && iso_en && ret_save);

    // R10
    on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_ON && !req_down) |=> status == STAT_ON);

endmodule

// File: tb/pwr_gate_seq_test.sv
module pwr_gate_seq_test;
    localparam int SWD = 2;
    localparam int ISD = 3;
    localparam int RTD = 4;
    localparam int NAK = 5;
    localparam int S   = SWD + ISD + RTD;
    localparam int P   = RTD + ISD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_down = 1'b0, req_up = 1'b0, dom_ack = 1'b0, err_clr = 1'b0;
    logic sw_en, iso_en, ret_save, busy, done, err;
    logic [2:0] status;
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    pwr_gate_seq #(.SW_DLY(SWD), .ISO_DLY(ISD), .RET_DLY(RTD), .ACK_LIMIT(NAK)) uut (
        .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
        .dom_ack(dom_ack), .err_clr(err_clr), .sw_en(sw_en), .iso_en(iso_en),
        .ret_save(ret_save), .busy(busy), .done(done), .err(err), .status(status)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag, input int e_st, input int e_sw, input int e_iso,
                           input int e_ret, input int e_done, input int e_err);
        chk(tag, "status R11", int'(status), e_st);
        chk(tag, "busy R12", int'(busy), (e_st == 1 || e_st == 3) ? 1 : 0);
        chk(tag, "sw_en", int'(sw_en), e_sw);
        chk(tag, "iso_en", int'(iso_en), e_iso);
        chk(tag, "ret_save", int'(ret_save), e_ret);
        chk(tag, "done", int'(done), e_done);
        chk(tag, "err", int'(err), e_err);
    endtask

    // d in 1..NAK: ack sampled d edges after save step; d=0: no ack (timeout)
    task automatic run_down(input int d);
        int last = (d == 0) ? S + NAK + 1 : S + d + 1;
        req_down = 1'b1;
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            req_down = 1'b0; req_up = 1'b0; dom_ack = 1'b0;
            if (i < last)
                chk_all("R2 R3 R4 R10", 1, (i <= SWD) ? 1 : 0, (i > SWD + ISD) ? 1 : 0,
                        (i > S) ? 1 : 0, 0, 0);
            else if (d > 0)
                chk_all("R5", 2, 0, 1, 1, 1, 0);
            else
                chk_all("R8", 4, 0, 1, 1, 0, 1);
            if (i == 1) dom_ack = 1'b1;
            if (i == 2) req_up = 1'b1;
            if (i == 3) req_down = 1'b1;
            if (d > 0 && i == S + d) dom_ack = 1'b1;
        end
        @(negedge clk);
        if (d > 0) chk_all("R5", 2, 0, 1, 1, 0, 0);
        else       chk_all("R8", 4, 0, 1, 1, 0, 1);
    endtask

    task automatic run_up(input int d);
        int last = (d == 0) ? P + NAK + 1 : P + d + 1;
        req_up = 1'b1;
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            req_down = 1'b0; req_up = 1'b0; dom_ack = 1'b0;
            if (i < last)
                chk_all("R6 R10", 3, (i > P) ? 1 : 0, 1, (i <= RTD) ? 1 : 0, 0, 0);
            else if (d > 0)
                chk_all("R7", 0, 1, 0, 0, 1, 0);
            else
                chk_all("R8", 4, 1, 1, 0, 0, 1);
            if (i == 1) dom_ack = 1'b1;
            if (i == 2) req_down = 1'b1;
            if (i == 3) req_up = 1'b1;
            if (d > 0 && i == P + d) dom_ack = 1'b1;
        end
        @(negedge clk);
        if (d > 0) chk_all("R7", 0, 1, 0, 0, 0, 0);
        else       chk_all("R8", 4, 1, 1, 0, 0, 1);
    endtask

    task automatic fault_hold_and_clear;
        req_up = 1'b1; req_down = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "status in ERROR", int'(status), 4);
            chk("R9", "err sticky", int'(err), 1);
        end
        req_up = 1'b0; req_down = 1'b0; err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk_all("R9", 2, 0, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 1, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 1, 0, 0, 0, 0);
        // R10: req_up and ack in ON have no effect
        req_up = 1'b1; dom_ack = 1'b1;
        @(negedge clk);
        req_up = 1'b0; dom_ack = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk_all("R10", 0, 1, 0, 0, 0, 0);
        end
        for (int d = 1; d <= NAK; d++) begin
            run_down(d);
            // R10: req_down and ack in OFF have no effect
            req_down = 1'b1; dom_ack = 1'b1;
            @(negedge clk);
            req_down = 1'b0; dom_ack = 1'b0;
            @(negedge clk);
            chk_all("R10", 2, 0, 1, 1, 0, 0);
            run_up(d);
        end
        run_down(0);
        fault_hold_and_clear();
        run_up(0);
        fault_hold_and_clear();
        run_up(3);
        run_down(NAK);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule